// File: doc/BRIEF.md
# Banked Interrupt Priority Store

This block holds an 8-bit priority for every interrupt of an interrupt controller. A byte-wide register port reads and writes these priorities. Each access carries the requesting CPU number and a secure/non-secure attribute. Interrupts with an ID below the banking limit (32) keep a separate priority for each CPU. Interrupts at or above that limit share one entry, whichever CPU accesses it.

When security is on, a non-secure access works through a translated view. A write is stored with the top bit forced and the value halved, so non-secure software can only reach the lower-urgency half of the range. A read is shifted left to undo that halving. Interrupts in the secure group are hidden from non-secure accesses altogether. The group bit of the addressed interrupt arrives as an input from a separate group store.

A second, combinational port serves the interrupt selector. It returns the stored priority of any (CPU, ID) pair, and the group priority after the binary-point mask has been applied. An optional parameter keeps only the upper bits of each priority.

Top module: `prio_bank_regs`

## Requirements
- R1: For IDs below 32, a write by one CPU changes only that CPU's copy. Reads and lookups by each CPU return that CPU's own value.
- R2: For IDs of 32 and above, one entry is shared. A write by any CPU is seen by every CPU.
- R3: A secure access, or any access while `secEn` is low, writes and reads the stored byte unchanged (apart from R10 masking).
- R4: With `secEn` high, a non-secure write to a Group 1 interrupt (`reqGroup`=1) stores `0x80 | (wdata >> 1)`.
- R5: With `secEn` high, a non-secure write to a Group 0 interrupt (`reqGroup`=0) leaves the stored priority unchanged.
- R6: With `secEn` high, a non-secure read of a Group 0 interrupt returns 0.
- R7: With `secEn` high, a non-secure read of a Group 1 interrupt returns `(stored << 1) & 0xFF`.
- R8: Priority bytes sit at byte offset 0x400 + ID. An address below 0x400, or at or beyond 0x400 + `NUM_IRQ`, gets `rspErr`=1 and `rspRdata`=0, and changes no stored priority.
- R9: Reset clears every priority to 0, and `rspValid` reads 0.
- R10: Only the top `PRIO_BITS` bits of a priority are kept. The lower bits always read as 0, through both the bus and the lookup.
- R11: `lkGrpPrio` equals `lkPrio & (0xFF << (b + 1))`, where the shifted mask is cut to 8 bits. Here `b` is `(lkAliasBinPt - 1) mod 8` when `lkGroup`=1 and `lkCommonBp`=0, and `lkBinPt` otherwise.
- R12: Every access gets exactly one response, with `rspValid` high in the cycle after the request cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secEn | input | 1 | Security enabled |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqNonSec | input | 1 | Access is non-secure |
| reqGroup | input | 1 | Group of the addressed interrupt for the requesting CPU (1 = Group 1) |
| reqCpu | input | CPU_W | Requesting CPU |
| reqAddr | input | ADDR_W | Byte offset of the access |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | Response valid |
| rspErr | output | 1 | Access rejected |
| rspRdata | output | 8 | Read byte |
| lkCpu | input | CPU_W | Lookup CPU |
| lkId | input | IDW | Lookup interrupt ID |
| lkGroup | input | 1 | Group of the looked-up interrupt |
| lkCommonBp | input | 1 | Common binary point selected |
| lkBinPt | input | 3 | Binary point |
| lkAliasBinPt | input | 3 | Aliased binary point |
| lkPrio | output | 8 | Stored priority of the lookup entry (0 if the ID is out of range) |
| lkGrpPrio | output | 8 | Group priority after binary-point masking |

## Verification
The bench builds two copies side by side, both with 2 CPUs and 40 interrupts. One keeps all 8 priority bits and the other keeps 5. This leaves 8 shared entries next to the 32 banked ones, so a full sweep reaches every entry for both CPUs and crosses the banked/shared boundary at ID 32. The 5-bit copy shows masking on top of the non-secure translation. Because every binary-point, aliased-point, group and common-point combination is swept, every mask width from 8 shifts down to 1 is checked.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;
  // Strobes from the access control to the priority datapath
  typedef struct packed {
    logic       acc;     // access presented this cycle
    logic       wrEn;    // commit write data
    logic       rdEn;    // legal read
    logic       err;     // rejected access
    logic       rdZero;  // read hidden from non-secure view
    logic       nsView;  // translated (non-secure) view
    logic [7:0] wdata;   // translated and masked write byte
  } prioStrobe_t;
endpackage

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_bank_pkg::*;
#(
  parameter int NUM_CPU   = 2,
  parameter int NUM_IRQ   = 64,
  parameter int ADDR_W    = 12,
  parameter int BASE      = 'h400,
  parameter int PRIO_BITS = 8,
  localparam int IDW      = $clog2(NUM_IRQ),
  localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqNonSec,
  input  logic              reqGroup,
  input  logic              secEn,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output prioStrobe_t       strb,
  output logic [IDW-1:0]    idx
);
  localparam logic [7:0] PRIO_MASK = 8'(8'hFF << (8 - PRIO_BITS));

  logic [ADDR_W-1:0] rel;
  logic inWin, cpuOk, blocked;
  logic [7:0] viewData;

  always_comb begin
    rel      = reqAddr - ADDR_W'(BASE);
    inWin    = (reqAddr >= ADDR_W'(BASE)) && (rel < ADDR_W'(NUM_IRQ));
    cpuOk    = 32'(reqCpu) < 32'(NUM_CPU);
    idx      = rel[IDW-1:0];
    // non-secure view only applies when security is on
    strb.nsView = reqNonSec && secEn;
    blocked  = strb.nsView && !reqGroup;
    viewData = strb.nsView ? {1'b1, reqWdata[7:1]} : reqWdata;
    strb.acc    = reqValid;
    strb.err    = reqValid && !(inWin && cpuOk);
    strb.wrEn   = reqValid && reqWrite && !strb.err && !blocked;
    strb.rdEn   = reqValid && !reqWrite && !strb.err;
    strb.rdZero = blocked;
    strb.wdata  = viewData & PRIO_MASK;
  end
endmodule

// File: rtl/prio_datapath.sv
module prio_datapath
  import prio_bank_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_IRQ    = 64,
  parameter int NUM_BANKED = 32,
  parameter int PRIO_BITS  = 8,
  localparam int IDW       = $clog2(NUM_IRQ),
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  prioStrobe_t      strb,
  input  logic [IDW-1:0]   idx,
  input  logic [CPU_W-1:0] reqCpu,
  output logic             rspValid,
  output logic             rspErr,
  output logic [7:0]       rspRdata,
  input  logic [CPU_W-1:0] lkCpu,
  input  logic [IDW-1:0]   lkId,
  input  logic             lkGroup,
  input  logic             lkCommonBp,
  input  logic [2:0]       lkBinPt,
  input  logic [2:0]       lkAliasBinPt,
  output logic [7:0]       lkPrio,
  output logic [7:0]       lkGrpPrio
);
  localparam logic [7:0] PRIO_MASK = 8'(8'hFF << (8 - PRIO_BITS));

  // Flattened view: banked IDs get one register per CPU,
  // shared IDs drive one register into every CPU column.
  logic [7:0] view [NUM_CPU][NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gEnt
    if (g < NUM_BANKED) begin : gBank
      for (genvar c = 0; c < NUM_CPU; c++) begin : gCpu
        logic [7:0] q;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) q <= '0;
          else if (strb.wrEn && idx == IDW'(g) && reqCpu == CPU_W'(c)) q <= strb.wdata;
        end
        assign view[c][g] = q;
      end
    end else begin : gShr
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= '0;
        else if (strb.wrEn && idx == IDW'(g)) q <= strb.wdata;
      end
      for (genvar c = 0; c < NUM_CPU; c++) begin : gFan
        assign view[c][g] = q;
      end
    end
  end

  logic [7:0] rdRaw, rdOut;
  logic       lkOk;
  logic [2:0] bprEff;
  logic [3:0] shAmt;

  always_comb begin
    rdRaw  = view[reqCpu][idx];
    rdOut  = strb.rdZero ? 8'h00 : (strb.nsView ? {rdRaw[6:0], 1'b0} : rdRaw);
    lkOk   = (32'(lkId) < 32'(NUM_IRQ)) && (32'(lkCpu) < 32'(NUM_CPU));
    lkPrio = lkOk ? view[lkCpu][lkId] : 8'h00;
    bprEff = (lkGroup && !lkCommonBp) ? (lkAliasBinPt - 3'd1) : lkBinPt;
    shAmt  = {1'b0, bprEff} + 4'd1;
    lkGrpPrio = lkPrio & 8'(8'hFF << shAmt);
  end

  logic rspNs;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
      rspNs    <= 1'b0;
    end else begin
      rspValid <= strb.acc;
      rspErr   <= strb.err;
      rspRdata <= strb.rdEn ? rdOut : 8'h00;
      rspNs    <= strb.rdEn && strb.nsView;
    end
  end

  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (lkPrio & ~PRIO_MASK) == 8'h00); // R10
  AST_NS_READ_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspNs) |-> !rspRdata[0]); // R7
  AST_GRP_SUBSET: assert property (@(posedge clk) disable iff (!rstN)
    ((lkGrpPrio & ~lkPrio) == 8'h00) && !lkGrpPrio[0]); // R11
endmodule

// File: rtl/prio_bank_regs.sv
module prio_bank_regs
  import prio_bank_pkg::*;
#(
  parameter int NUM_CPU    = 2,
  parameter int NUM_IRQ    = 64,
  parameter int NUM_BANKED = 32,
  parameter int ADDR_W     = 12,
  parameter int BASE       = 'h400,
  parameter int PRIO_BITS  = 8,
  localparam int IDW       = $clog2(NUM_IRQ),
  localparam int CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secEn,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqNonSec,
  input  logic              reqGroup,
  input  logic [CPU_W-1:0]  reqCpu,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [7:0]        rspRdata,
  input  logic [CPU_W-1:0]  lkCpu,
  input  logic [IDW-1:0]    lkId,
  input  logic              lkGroup,
  input  logic              lkCommonBp,
  input  logic [2:0]        lkBinPt,
  input  logic [2:0]        lkAliasBinPt,
  output logic [7:0]        lkPrio,
  output logic [7:0]        lkGrpPrio
);
  prioStrobe_t    strb;
  logic [IDW-1:0] idx;

  prio_ctrl #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W),
    .BASE(BASE), .PRIO_BITS(PRIO_BITS)
  ) uCtrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqNonSec(reqNonSec),
    .reqGroup(reqGroup), .secEn(secEn), .reqCpu(reqCpu),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .strb(strb), .idx(idx)
  );

  prio_datapath #(
    .NUM_CPU(NUM_CPU), .NUM_IRQ(NUM_IRQ), .NUM_BANKED(NUM_BANKED),
    .PRIO_BITS(PRIO_BITS)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .idx(idx), .reqCpu(reqCpu),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .lkCpu(lkCpu), .lkId(lkId), .lkGroup(lkGroup), .lkCommonBp(lkCommonBp),
    .lkBinPt(lkBinPt), .lkAliasBinPt(lkAliasBinPt),
    .lkPrio(lkPrio), .lkGrpPrio(lkGrpPrio)
  );

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R12
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R12
  AST_G0_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqNonSec && secEn && !reqGroup && !strb.err
     && lkId == idx && lkCpu == reqCpu)
    |=> (!($stable(lkId) && $stable(lkCpu)) || $stable(lkPrio))); // R5
  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |=> (!($stable(lkId) && $stable(lkCpu)) || $stable(lkPrio))); // R8
endmodule

// File: tb/sim_prio_bank_regs.sv
module sim_prio_bank_regs;
  localparam int NCPU = 2;
  localparam int NIRQ = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic secEn = 0, reqValid = 0, reqWrite = 0, reqNonSec = 0, reqGroup = 0;
  logic reqCpu = 0;
  logic [11:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic lkCpu = 0;
  logic [5:0] lkId = '0;
  logic lkGroup = 0, lkCommonBp = 0;
  logic [2:0] lkBinPt = '0, lkAliasBinPt = '0;
  logic rspValid [2];
  logic rspErr [2];
  logic [7:0] rspRdata [2];
  logic [7:0] lkPrio [2];
  logic [7:0] lkGrpPrio [2];

  prio_bank_regs #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ), .PRIO_BITS(8)) u0 (
    .clk(clk), .rstN(rstN), .secEn(secEn), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqNonSec(reqNonSec), .reqGroup(reqGroup), .reqCpu(reqCpu), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid[0]), .rspErr(rspErr[0]), .rspRdata(rspRdata[0]),
    .lkCpu(lkCpu), .lkId(lkId), .lkGroup(lkGroup), .lkCommonBp(lkCommonBp),
    .lkBinPt(lkBinPt), .lkAliasBinPt(lkAliasBinPt), .lkPrio(lkPrio[0]), .lkGrpPrio(lkGrpPrio[0]));

  prio_bank_regs #(.NUM_CPU(NCPU), .NUM_IRQ(NIRQ), .PRIO_BITS(5)) u1 (
    .clk(clk), .rstN(rstN), .secEn(secEn), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqNonSec(reqNonSec), .reqGroup(reqGroup), .reqCpu(reqCpu), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspValid(rspValid[1]), .rspErr(rspErr[1]), .rspRdata(rspRdata[1]),
    .lkCpu(lkCpu), .lkId(lkId), .lkGroup(lkGroup), .lkCommonBp(lkCommonBp),
    .lkBinPt(lkBinPt), .lkAliasBinPt(lkAliasBinPt), .lkPrio(lkPrio[1]), .lkGrpPrio(lkGrpPrio[1]));

  int nRun = 0;
  int nFail = 0;
  int mdl [2][NCPU][NIRQ];
  int msk [2] = '{255, 248};

  task automatic check(string req, string what, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(bit wr, bit ns, bit cpu, int addr, int wd, bit grp, string req);
    bit eff;
    bit bad;
    int id;
    int exp;
    int v;
    eff = ns && secEn;
    bad = (addr < 'h400) || (addr >= 'h400 + NIRQ);
    id  = addr - 'h400;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqNonSec = ns; reqCpu = cpu;
    reqAddr = 12'(addr); reqWdata = 8'(wd); reqGroup = grp;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 2; i++) begin
      check(req, "rspValid", int'(rspValid[i]), 1);
      check(req, "rspErr", int'(rspErr[i]), int'(bad));
      if (!wr) begin
        if (bad) exp = 0;
        else if (eff) exp = grp ? ((mdl[i][cpu][id] << 1) & 255) : 0;
        else exp = mdl[i][cpu][id];
        check(req, "rspRdata", int'(rspRdata[i]), exp);
      end else if (!bad && !(eff && !grp)) begin
        v = (eff ? (128 | (wd >> 1)) : wd) & msk[i];
        if (id < 32) mdl[i][cpu][id] = v;
        else for (int c = 0; c < NCPU; c++) mdl[i][c][id] = v;
      end
    end
  endtask

  task automatic lookAll(string req);
    for (int c = 0; c < NCPU; c++) begin
      for (int id = 0; id < NIRQ; id++) begin
        lkCpu = 1'(c); lkId = 6'(id);
        #1;
        for (int i = 0; i < 2; i++) check(req, "lkPrio", int'(lkPrio[i]), mdl[i][c][id]);
      end
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    #(20 * 150000);
    nFail++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++)
      for (int c = 0; c < NCPU; c++)
        for (int id = 0; id < NIRQ; id++) mdl[i][c][id] = 0;

    // R9: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < 2; i++) check("R9", "rspValid in reset", int'(rspValid[i]), 0);
    lookAll("R9");
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < 2; i++) check("R9", "rspValid after reset", int'(rspValid[i]), 0);
    lookAll("R9");

    secEn = 1;
    // R3/R10: secure writes of distinct values to every entry of both CPUs
    for (int c = 0; c < NCPU; c++)
      for (int id = 0; id < NIRQ; id++)
        access(1, 0, 1'(c), 'h400 + id, (id * 29 + c * 71 + 5) & 255, 0, "R3");
    // R1 banked / R2 shared readback over the bus, then the lookup port
    for (int c = 0; c < NCPU; c++)
      for (int id = 0; id < NIRQ; id++)
        access(0, 0, 1'(c), 'h400 + id, 0, 0, (id < 32) ? "R1" : "R2");
    lookAll("R2");
    lookAll("R10");

    // R4/R5: non-secure writes from CPU0, group varies per ID
    for (int id = 0; id < NIRQ; id++)
      access(1, 1, 0, 'h400 + id, (id * 37 + 11) & 255, (id % 3) != 0,
             ((id % 3) != 0) ? "R4" : "R5");
    lookAll("R5");
    // R6/R7: non-secure reads from CPU1
    for (int id = 0; id < NIRQ; id++)
      access(0, 1, 1, 'h400 + id, 0, (id % 2) != 0, ((id % 2) != 0) ? "R7" : "R6");

    // R3: security disabled, non-secure access acts unchanged
    secEn = 0;
    access(1, 1, 1, 'h400 + 5, 'hA5, 0, "R3");
    access(0, 1, 1, 'h400 + 5, 0, 0, "R3");
    access(1, 1, 0, 'h400 + 36, 'h3C, 0, "R3");
    access(0, 1, 1, 'h400 + 36, 0, 0, "R3");
    lookAll("R3");
    secEn = 1;

    // R8: rejected addresses
    access(0, 0, 0, 'h3FF, 0, 1, "R8");
    access(1, 0, 1, 'h400 + NIRQ, 'h5A, 1, "R8");
    access(1, 0, 0, 'h3FF, 'hFF, 1, "R8");
    access(1, 1, 0, 'hFFF, 'h11, 1, "R8");
    lookAll("R8");

    // R12: response lasts exactly one cycle
    @(negedge clk);
    for (int i = 0; i < 2; i++) check("R12", "rspValid idle", int'(rspValid[i]), 0);

    // R11: binary point masking sweep
    for (int k = 0; k < 2; k++) begin
      lkCpu = 1'(k);
      lkId  = (k == 0) ? 6'd3 : 6'd35;
      for (int bp = 0; bp < 8; bp++)
        for (int abp = 0; abp < 8; abp++)
          for (int g = 0; g < 2; g++)
            for (int cb = 0; cb < 2; cb++) begin
              int b;
              lkBinPt = 3'(bp); lkAliasBinPt = 3'(abp);
              lkGroup = g[0]; lkCommonBp = cb[0];
              #1;
              b = (g == 1 && cb == 0) ? ((abp - 1) & 7) : bp;
              for (int i = 0; i < 2; i++)
                check("R11", "lkGrpPrio", int'(lkGrpPrio[i]),
                      mdl[i][k][int'(lkId)] & ((255 << (b + 1)) & 255));
            end
    end

    summary();
    $finish;
  end
endmodule